// File: doc/BRIEF.md
# Programmable 16x8 Bus RAM

A small word-addressed memory of sixteen 8-bit locations that sits on a shared bidirectional system bus. A 4-bit address selects the location. Reads place the selected word onto the shared data port only while read enable is high. At every other time the port floats, so other bus agents can use it.

Writes can take their word from either of two sources. In program mode a dedicated program-data input supplies the word, so an operator can fill the memory before normal running begins. Outside program mode the word comes from whatever is on the shared data port. Writes land on the rising clock edge while write enable is high. A synchronous reset clears every location. When read and write enables are both high, the write is performed and the port is left undriven, so the block never fights its own write data.

Top module: `prog_bus_ram`

## Requirements
- R1: The memory holds 16 independent 8-bit words selected by the 4-bit `addr`; distinct values written to all 16 addresses all read back distinctly.
- R2: While `rst` is high at a rising clock edge, every location becomes 8'h00. This holds both at start-up and in the middle of operation.
- R3: While `rd_en` is low, `data_io` is not driven by the block. This includes cycles in program mode with `wr_en` high.
- R4: While `rd_en` is high and `wr_en` is low, `data_io` carries the word stored at `addr` in the same cycle, with no clock edge needed.
- R5: With `prog_mode` high and `wr_en` high at a rising edge, `prog_data` is stored at `addr`; the value present on `data_io` is ignored.
- R6: With `prog_mode` low and `wr_en` high at a rising edge, the value on `data_io` is stored at `addr`; `prog_data` is ignored.
- R7: A word written through `data_io` at an address reads back unchanged from that address.
- R8: With `rd_en` and `wr_en` both high, the write is performed and `data_io` is not driven by the block.
- R9: A rising edge with `wr_en` low (and `rst` low) changes no location, whatever is on `data_io` or `prog_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all locations |
| addr | input | 4 | Word select for reads and writes |
| rd_en | input | 1 | Drive the addressed word onto `data_io` |
| wr_en | input | 1 | Store a word at `addr` on the next rising edge |
| prog_mode | input | 1 | 1: write word from `prog_data`; 0: write word from `data_io` |
| prog_data | input | 8 | Word source used in program mode |
| data_io | inout | 8 | Shared bus data; driven only during reads |

## Verification
A wrong stored word shows at the port during the first read of that address. Because reads are combinational, a corrupted location appears in the same cycle the address is presented. A wrong source selection or a missed reset therefore becomes visible on the read-back cycle right after the write or reset edge. Errors in tristate control are caught by a bench probe value on the bus: a stray drive from the block corrupts the probe in the very cycle it happens. This covers idle cycles, programming cycles and simultaneous read-write cycles.

// File: rtl/prog_bus_ram_pkg.sv
package prog_bus_ram_pkg;

   typedef enum logic {
      WSRC_PORT = 1'b0,
      WSRC_PROG = 1'b1
   } wsrc_e;

   function automatic wsrc_e pick_source(input logic prog_mode);
      return prog_mode ? WSRC_PROG : WSRC_PORT;
   endfunction

endpackage

// File: rtl/pbr_src_sel.sv
module pbr_src_sel
   import prog_bus_ram_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              prog_mode,
   input  logic [DATA_W-1:0] prog_word,
   input  logic [DATA_W-1:0] port_word,
   output logic [DATA_W-1:0] wr_word
);

   wsrc_e src;

   always_comb begin
      src = pick_source(prog_mode);
      unique case (src)
         WSRC_PROG: wr_word = prog_word;
         default:   wr_word = port_word;
      endcase
   end

endmodule

// File: rtl/pbr_store.sv
module pbr_store #(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] rd_word
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (rst) begin
                  cells[i] <= '0;
               end else if (wr_go && (addr == ADDR_W'(i))) begin
                  cells[i] <= wr_word;
               end
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (wr_go && (addr == ADDR_W'(i))) begin
                  cells[i] <= wr_word;
               end
            end
         end
      end
   endgenerate

   always_comb rd_word = cells[addr];

endmodule

// File: rtl/pbr_port_ctl.sv
module pbr_port_ctl #(
   parameter int DATA_W = 8
) (
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] rd_word,
   output logic              drive,
   output logic [DATA_W-1:0] out_word
);

   always_comb begin
      drive    = rd_en && !wr_en;
      out_word = drive ? rd_word : '0;
   end

endmodule

// File: rtl/prog_bus_ram.sv
module prog_bus_ram #(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              prog_mode,
   input  logic [DATA_W-1:0] prog_data,
   inout  wire  [DATA_W-1:0] data_io
);

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("prog_bus_ram: ADDR_W must lie in 1..10");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("prog_bus_ram: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] port_in;
   logic [DATA_W-1:0] wr_word;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] out_word;
   logic              drive;

   assign port_in = data_io;

   pbr_src_sel #(.DATA_W(DATA_W)) u_src (
      .prog_mode (prog_mode),
      .prog_word (prog_data),
      .port_word (port_in),
      .wr_word   (wr_word)
   );

   pbr_store #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_go   (wr_en),
      .addr    (addr),
      .wr_word (wr_word),
      .rd_word (rd_word)
   );

   pbr_port_ctl #(.DATA_W(DATA_W)) u_port (
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .rd_word  (rd_word),
      .drive    (drive),
      .out_word (out_word)
   );

   assign data_io = drive ? out_word : {DATA_W{1'bz}};

endmodule

// File: rtl/prog_bus_ram_chk.sv
module prog_bus_ram_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_en,
   input logic              wr_en,
   input logic              prog_mode,
   input logic [DATA_W-1:0] prog_data,
   input logic [DATA_W-1:0] port_in,
   input logic [DATA_W-1:0] rd_word,
   input logic              drive
);

   logic              valid_q;
   logic              rst_q;
   logic              wr_q;
   logic              pm_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] pd_q;
   logic [DATA_W-1:0] din_q;

   always_ff @(posedge clk) begin
      rst_q   <= rst;
      valid_q <= !rst;
      wr_q    <= wr_en;
      pm_q    <= prog_mode;
      addr_q  <= addr;
      pd_q    <= prog_data;
      din_q   <= port_in;
   end

   // R2
   a_r2_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (rd_word == '0));

   // R3
   a_r3_released_when_idle: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> !drive);

   // R4
   a_r4_read_drives: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !wr_en) |-> drive);

   // R5
   a_r5_prog_word_stored: assert property (@(posedge clk) disable iff (rst)
      (valid_q && wr_q && pm_q && addr == addr_q) |-> (rd_word == pd_q));

   // R6
   a_r6_port_word_stored: assert property (@(posedge clk) disable iff (rst)
      (valid_q && wr_q && !pm_q && addr == addr_q) |-> (rd_word == din_q));

   // R8
   a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !drive);

   // R9
   a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !wr_q && addr == addr_q) |-> $stable(rd_word));

endmodule

bind prog_bus_ram prog_bus_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .addr      (addr),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .prog_mode (prog_mode),
   .prog_data (prog_data),
   .port_in   (port_in),
   .rd_word   (rd_word),
   .drive     (drive)
);

// File: tb/tb_prog_bus_ram.sv
module tb_prog_bus_ram;

   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int WORDS = 1 << AW;
   localparam logic [DW-1:0] PROBE = 8'hA5;

   typedef struct {
      logic [DW-1:0] exp;
      string         req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic          prog_mode = 1'b0;
   logic [DW-1:0] prog_data = '0;
   logic          bus_oe = 1'b0;
   logic [DW-1:0] bus_drv = '0;
   wire  [DW-1:0] data_io;

   assign data_io = bus_oe ? bus_drv : {DW{1'bz}};

   item_t q[$];
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   prog_bus_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .prog_mode(prog_mode), .prog_data(prog_data), .data_io(data_io)
   );

   function automatic logic [DW-1:0] pat(input int i);
      return DW'(i * 37 + 11);
   endfunction

   // monitor: compares the port mid-cycle against queued expectations
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (data_io !== it.exp) begin
               bad++;
               $display("FAIL %s got=%h exp=%h", it.req, data_io, it.exp);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      step();
      rd_en = 1'b0; wr_en = 1'b0; prog_mode = 1'b0; bus_oe = 1'b0;
   endtask

   task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
      step();
      addr = AW'(a); rd_en = 1'b1; wr_en = 1'b0; prog_mode = 1'b0; bus_oe = 1'b0;
      q.push_back('{exp: e, req: tag});
   endtask

   // program-mode write; a probe sits on the bus and must be seen intact
   task automatic prog_wr(input int a, input logic [DW-1:0] d);
      step();
      addr = AW'(a); rd_en = 1'b0; wr_en = 1'b1; prog_mode = 1'b1;
      prog_data = d; bus_oe = 1'b1; bus_drv = PROBE;
      q.push_back('{exp: PROBE, req: "R3 hi-Z while programming"});
   endtask

   task automatic port_wr(input int a, input logic [DW-1:0] d, input logic re);
      step();
      addr = AW'(a); rd_en = re; wr_en = 1'b1; prog_mode = 1'b0;
      prog_data = ~d; bus_oe = 1'b1; bus_drv = d;
      if (re) q.push_back('{exp: d, req: "R8 port undriven on read+write"});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R2: reset state of every location
      for (int i = 0; i < WORDS; i++) rd(i, '0, "R2 cleared at start");

      // R1/R5: program all words with distinct values
      for (int i = 0; i < WORDS; i++) prog_wr(i, pat(i));
      for (int i = 0; i < WORDS; i++) rd(i, pat(i), "R1 R4 R5 programmed word");

      // R3: idle with probe on bus
      step();
      addr = 4'd0; rd_en = 1'b0; wr_en = 1'b0; bus_oe = 1'b1; bus_drv = PROBE;
      q.push_back('{exp: PROBE, req: "R3 hi-Z when not reading"});

      // R9: edges with wr_en low change nothing
      step();
      addr = 4'd5; prog_mode = 1'b1; prog_data = 8'h77; bus_drv = 8'h99;
      step();
      prog_mode = 1'b0;
      rd(5, pat(5), "R9 no write without enable");

      // R6/R7: port write, prog_data ignored
      port_wr(2, 8'hCC, 1'b0);
      rd(2, 8'hCC, "R6 R7 port word read back");
      port_wr(9, 8'h3C, 1'b0);
      rd(9, 8'h3C, "R6 R7 second port word");
      rd(8, pat(8), "R1 neighbour untouched");

      // R8: simultaneous read and write
      port_wr(7, 8'h5A, 1'b1);
      rd(7, 8'h5A, "R8 write performed");

      // R2: reset mid-run
      idle();
      rst = 1'b1;
      step();
      rst = 1'b0;
      rd(2, '0, "R2 cleared mid-run");
      rd(15, '0, "R2 cleared mid-run top");
      idle();
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule